// File: doc/BRIEF.md
# Shared Power Island State Arbiter

This block decides the power state of one power island that several devices share. Each device that wants a state sends a request with its requester ID and a desired power state. The block keeps a small table of up to four requesters and the last state each one asked for. It resolves the island state as the numerically lowest, and so shallowest, state in that table. That is the deepest state the island can enter without taking power from any of its users.

When the resolved state changes, the block raises a one-cycle update strobe for the downstream power controller. A fifth distinct requester does not fit in the table. In that case the block raises a one-cycle overflow flag, and only for that request it seeds the resolution with the requester's own state. A synchronous clear empties the table.

Requests arrive on a valid/ready interface. `req_ready_o` is high in every cycle except while `clear_i` is asserted. A request is consumed on a rising edge where both `req_valid_i` and `req_ready_o` are high. A requester must hold its ID and state stable while valid is high and ready is low. The resolved state, update strobe and overflow flag appear on the registered outputs in the cycle after acceptance.

Top module: `pda_arbiter`

## Requirements
- R1: After reset, `island_state_o` is 3 (the deepest state), `update_o` and `overflow_o` are 0, and every table slot is empty.
- R2: `req_ready_o` is low while `clear_i` is high and high otherwise. A request is accepted on a rising edge with valid and ready both high, and its result is on the outputs in the following cycle.
- R3: A requested state above 3 on the 3-bit `req_state_i` is treated as 3. Values 0 to 3 are used as given.
- R4: An accepted request goes to the lowest-indexed slot that either holds the same requester ID or is empty. That slot then stores the ID and the (clamped) state.
- R5: Without overflow, the resolved state is the minimum of 3 and every slot's stored state, including the slot just written.
- R6: If no slot matches and none is empty, `overflow_o` pulses for one cycle and the table is left unchanged. The resolved state is then the minimum of the request's own clamped state and all stored states.
- R7: `update_o` pulses for one cycle exactly when the newly registered resolved state differs from the previous one.
- R8: Requester ID 0 marks an empty slot. A request carrying ID 0 is accepted but has no effect on the table or the outputs, and `update_o` and `overflow_o` stay 0.
- R9: A cycle with `clear_i` high empties every slot, sets every stored state to 3 and sets the resolved state to 3. `update_o` pulses if the resolved state was not already 3, and `overflow_o` stays 0.
- R10: In a cycle with no accepted request and no clear, the resolved state holds and neither strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous table clear |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_id_i | input | ID_W | Requester ID (0 is reserved) |
| req_state_i | input | 3 | Desired power state, clamped to 0..3 |
| island_state_o | output | 2 | Registered resolved island state |
| update_o | output | 1 | One-cycle pulse when the resolved state changes |
| overflow_o | output | 1 | One-cycle pulse when a request found no slot |

## Verification
The bench builds the block with its defaults: four slots and 4-bit requester IDs. With only four slots, a fifth distinct ID is reached after a few requests, so the overflow path runs right after the table fills. The 3-bit request state covers every value that needs clamping. The vector walk covers several cases: a requester raising its state so that the minimum moves to another slot, and an overflow request whose state lowers the result without being stored. It also covers a clear followed by refilling from slot 0, a clear that needs no strobe, and a clear that coincides with a request which must not be taken.

// File: rtl/pda_pkg.sv
package pda_pkg;
  localparam int unsigned PSTATE_W = 2;
  typedef logic [PSTATE_W-1:0] pstate_t;
  localparam pstate_t PS_SHALLOW = 2'd0;
  localparam pstate_t PS_DEEP    = 2'd3;

  // Bring any wider request into the supported range of power states.
  function automatic pstate_t clamp_state(input logic [2:0] raw);
    if (raw > 3'(PS_DEEP)) return PS_DEEP;
    return pstate_t'(raw);
  endfunction
endpackage

// File: rtl/pda_slot_match.sv
module pda_slot_match #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned ID_W  = 4
) (
  input  logic [SLOTS-1:0][ID_W-1:0] slot_id_i,
  input  logic [ID_W-1:0]            req_id_i,
  output logic [SLOTS-1:0]           sel_o,
  output logic                       found_o
);
  logic [SLOTS-1:0] cand;
  logic [SLOTS:0]   taken;

  assign taken[0] = 1'b0;
  for (genvar i = 0; i < SLOTS; i++) begin : g_scan
    // A slot qualifies if it already belongs to this requester or is free.
    assign cand[i]    = (slot_id_i[i] == req_id_i) || (slot_id_i[i] == '0);
    assign sel_o[i]   = cand[i] && !taken[i];
    assign taken[i+1] = taken[i] || cand[i];
  end
  assign found_o = taken[SLOTS];
endmodule

// File: rtl/pda_slot_table.sv
module pda_slot_table
  import pda_pkg::*;
#(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned ID_W  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       we_i,
  input  logic [SLOTS-1:0]           sel_i,
  input  logic [ID_W-1:0]            wr_id_i,
  input  pstate_t                    wr_state_i,
  output logic [SLOTS-1:0][ID_W-1:0] id_o,
  output pstate_t [SLOTS-1:0]        state_o
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_o[i]    <= '0;
        state_o[i] <= PS_DEEP;
      end else if (clear_i) begin
        id_o[i]    <= '0;
        state_o[i] <= PS_DEEP;
      end else if (we_i && sel_i[i]) begin
        id_o[i]    <= wr_id_i;
        state_o[i] <= wr_state_i;
      end
    end
  end
endmodule

// File: rtl/pda_min_reduce.sv
module pda_min_reduce
  import pda_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  pstate_t            seed_i,
  input  pstate_t [N-1:0]    val_i,
  output pstate_t            min_o
);
  pstate_t acc [N+1];
  assign acc[0] = seed_i;
  for (genvar i = 0; i < N; i++) begin : g_stage
    assign acc[i+1] = (val_i[i] < acc[i]) ? val_i[i] : acc[i];
  end
  assign min_o = acc[N];
endmodule

// File: rtl/pda_arbiter.sv
module pda_arbiter
  import pda_pkg::*;
#(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned ID_W  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [ID_W-1:0] req_id_i,
  input  logic [2:0]      req_state_i,
  output logic [1:0]      island_state_o,
  output logic            update_o,
  output logic            overflow_o
);
  logic [SLOTS-1:0][ID_W-1:0] slot_id;
  pstate_t [SLOTS-1:0]        slot_state;
  pstate_t [SLOTS-1:0]        merged;
  logic [SLOTS-1:0]           sel;
  logic                       found;
  logic                       accept, effective;
  pstate_t                    req_clamped, seed, resolved, island_q;

  assign req_ready_o = !clear_i;
  assign accept      = req_valid_i && req_ready_o;
  assign effective   = accept && (req_id_i != '0);
  assign req_clamped = clamp_state(req_state_i);

  pda_slot_match #(.SLOTS(SLOTS), .ID_W(ID_W)) u_match (
    .slot_id_i (slot_id),
    .req_id_i  (req_id_i),
    .sel_o     (sel),
    .found_o   (found)
  );

  pda_slot_table #(.SLOTS(SLOTS), .ID_W(ID_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .we_i       (effective),
    .sel_i      (sel),
    .wr_id_i    (req_id_i),
    .wr_state_i (req_clamped),
    .id_o       (slot_id),
    .state_o    (slot_state)
  );

  // Resolve against the table as it will look after this request is stored.
  for (genvar i = 0; i < SLOTS; i++) begin : g_merge
    assign merged[i] = sel[i] ? req_clamped : slot_state[i];
  end
  assign seed = found ? PS_DEEP : req_clamped;

  pda_min_reduce #(.N(SLOTS)) u_min (
    .seed_i (seed),
    .val_i  (merged),
    .min_o  (resolved)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      island_q   <= PS_DEEP;
      update_o   <= 1'b0;
      overflow_o <= 1'b0;
    end else if (clear_i) begin
      island_q   <= PS_DEEP;
      update_o   <= (island_q != PS_DEEP);
      overflow_o <= 1'b0;
    end else if (effective) begin
      island_q   <= resolved;
      update_o   <= (resolved != island_q);
      overflow_o <= !found;
    end else begin
      update_o   <= 1'b0;
      overflow_o <= 1'b0;
    end
  end

  assign island_state_o = island_q;
endmodule

// File: rtl/pda_arbiter_chk.sv
module pda_arbiter_chk #(
  parameter int unsigned ID_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            clear_i,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [ID_W-1:0] req_id_i,
  input logic [1:0]      island_state_o,
  input logic            update_o,
  input logic            overflow_o
);
  p_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o == !clear_i);

  p_update_on_change_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> (island_state_o != $past(island_state_o)));

  p_stable_no_update_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_o |-> $stable(island_state_o));

  p_overflow_after_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $past(req_valid_i && req_ready_o));

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(req_valid_i && req_ready_o) && !clear_i) |=>
      ($stable(island_state_o) && !update_o && !overflow_o));

  p_id_zero_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (req_id_i == '0)) |=>
      ($stable(island_state_o) && !update_o && !overflow_o));

  p_clear_deep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> ((island_state_o == 2'd3) && !overflow_o));
endmodule

bind pda_arbiter pda_arbiter_chk #(.ID_W(ID_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .clear_i        (clear_i),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .req_id_i       (req_id_i),
  .island_state_o (island_state_o),
  .update_o       (update_o),
  .overflow_o     (overflow_o)
);

// File: tb/pda_arbiter_test.sv
module pda_arbiter_test;
  localparam int ID_W = 4;
  localparam int NV   = 15;
  // {clear, id[3:0], req_state[2:0], exp_state[1:0], exp_update, exp_overflow}
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 4'd1, 3'd3, 2'd3, 1'b0, 1'b0},  // R4 id1 -> slot0
    {1'b0, 4'd2, 3'd1, 2'd1, 1'b1, 1'b0},  // R5 R7 id2 -> slot1
    {1'b0, 4'd1, 3'd0, 2'd0, 1'b1, 1'b0},  // R4 id1 reuses slot0
    {1'b0, 4'd3, 3'd2, 2'd0, 1'b0, 1'b0},  // R7 no change
    {1'b0, 4'd1, 3'd3, 2'd1, 1'b1, 1'b0},  // R5 min moves to slot1
    {1'b0, 4'd4, 3'd5, 2'd1, 1'b0, 1'b0},  // R3 5 clamps to 3
    {1'b0, 4'd5, 3'd0, 2'd0, 1'b1, 1'b1},  // R6 fifth requester
    {1'b0, 4'd2, 3'd3, 2'd2, 1'b1, 1'b0},  // R6 id5 was not stored
    {1'b0, 4'd3, 3'd7, 2'd3, 1'b1, 1'b0},  // R3 7 clamps to 3
    {1'b0, 4'd0, 3'd0, 2'd3, 1'b0, 1'b0},  // R8 id0 ignored
    {1'b1, 4'd0, 3'd0, 2'd3, 1'b0, 1'b0},  // R9 clear, already deep
    {1'b0, 4'd6, 3'd2, 2'd2, 1'b1, 1'b0},  // R9 refill from slot0
    {1'b0, 4'd5, 3'd1, 2'd1, 1'b1, 1'b0},  // R4 slot1
    {1'b1, 4'd0, 3'd0, 2'd3, 1'b1, 1'b0},  // R9 clear with update
    {1'b0, 4'd7, 3'd6, 2'd3, 1'b0, 1'b0}   // R3 R9 table empty again
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            clear = 1'b0;
  logic            valid = 1'b0;
  logic            ready;
  logic [ID_W-1:0] id = '0;
  logic [2:0]      st = '0;
  logic [1:0]      island;
  logic            upd, ovf;
  int              n_chk = 0;
  int              n_bad = 0;
  bit              done = 1'b0;

  always #10 clk = ~clk;

  pda_arbiter #(.SLOTS(4), .ID_W(ID_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .req_valid_i(valid),
    .req_ready_o(ready), .req_id_i(id), .req_state_i(st),
    .island_state_o(island), .update_o(upd), .overflow_o(ovf)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 state", {2'b0, island}, 4'd3);
    check("R1 strobes", {2'b0, upd, ovf}, 4'd0);
    check("R2 ready idle", {3'b0, ready}, 4'd1);

    for (int i = 0; i < NV; i++) begin
      clear = VEC[i][11];
      valid = !VEC[i][11];
      id    = VEC[i][10:7];
      st    = VEC[i][6:4];
      step();
      clear = 1'b0;
      valid = 1'b0;
      check($sformatf("R5 vec%0d state", i), {2'b0, island}, {2'b0, VEC[i][3:2]});
      check($sformatf("R7 vec%0d update", i), {3'b0, upd}, {3'b0, VEC[i][1]});
      check($sformatf("R6 vec%0d overflow", i), {3'b0, ovf}, {3'b0, VEC[i][0]});
    end

    // R10: idle cycle holds state and drops strobes
    step();
    check("R10 hold", {2'b0, island}, 4'd3);
    check("R10 no strobe", {2'b0, upd, ovf}, 4'd0);

    // R2: a request alongside clear is not taken
    id = 4'd9; st = 3'd0; valid = 1'b1; clear = 1'b1;
    #1 check("R2 ready low in clear", {3'b0, ready}, 4'd0);
    step();
    clear = 1'b0; valid = 1'b0;
    check("R2 request during clear dropped", {2'b0, island}, 4'd3);
    // R2: result appears one cycle after acceptance
    id = 4'd9; st = 3'd1; valid = 1'b1;
    step();
    valid = 1'b0;
    check("R2 result next cycle", {2'b0, island}, 4'd1);
    check("R7 pulse", {3'b0, upd}, 4'd1);
    step();
    check("R7 pulse one cycle", {3'b0, upd}, 4'd0);

    // R1: reset mid-run returns to the deep state with an empty table
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    check("R1 after reset", {2'b0, island}, 4'd3);
    id = 4'd9; st = 3'd3; valid = 1'b1;
    step();
    valid = 1'b0;
    check("R1 table empty", {1'b0, island, ovf}, 4'b0110);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule